// File: doc/BRIEF.md
# Sorted-Stream Merge Join Unit

This unit joins two key streams that each arrive in ascending key order. Every element carries a key and a payload (typically a record ID). The unit walks both streams the way a merge does. Only the side with the smaller key moves forward, and when the keys are equal the unit emits every pairing of the equal-key entries from the two sides.

The output is a single stream of beats that lines up with the left input. Each left element that finds no partner yields one beat with its hit bit clear. Each left element that does find partners yields one beat per partner, with the hit bit set and the right payload attached. The hit bit therefore forms a match bitmask aligned with the emitted values, ready for a mask-driven compaction stage downstream.

A run of equal right keys is held in a small replay buffer. That buffered run is replayed once for every left element with the same key. The output side can stall, and a stall holds back both inputs, since the output may carry more beats than the inputs together. The join ends once either stream has delivered its last element and no buffered group is still pending. A right run longer than the buffer raises a sticky error flag.

Top module: `merge_join_unit`

## Requirements
- R1: After reset, outValid, joinDone and overflowErr are all 0.
- R2: When the left key is smaller than the right key, the left element is consumed and one beat is emitted with outHit=0, outKey and outLeftPay taken from that left element, and outRightPay=0. The right element is not consumed.
- R3: When the right key is smaller than the left key, the right element is consumed and no beat is emitted for it. Both inputs are never consumed in the same cycle.
- R4: For equal keys, every emitted beat has outHit=1, outKey equal to the shared key, outLeftPay from the left element and outRightPay from a right element with that key.
- R5: With a run of m equal left keys and n equal right keys (n at most DEPTH), exactly m*n hit beats are emitted. They come ordered by left element, and within each left element by right arrival order.
- R6: While outValid=1 and outReady=0, the output beat (key, both payloads, hit) is held unchanged on the next cycle.
- R7: joinDone rises after the left last element is consumed, or after the right last element is consumed outside a duplicate group. joinDone then stays high, and leftReady and rightReady stay 0.
- R8: If a right run holds more than DEPTH (default 16) equal keys, overflowErr becomes 1 and stays 1 until reset. Only the first DEPTH entries of the run are replayed.
- R9: If the right stream ends inside an equal-key run, every following left element with that key is still paired with the run. joinDone rises once a left element with a larger key is presented, or once the left last element has been replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| leftValid | input | 1 | Left element present |
| leftReady | output | 1 | Left element consumed this cycle |
| leftKey | input | 32 | Left key |
| leftPay | input | 32 | Left payload |
| leftLast | input | 1 | Left element is the final one |
| rightValid | input | 1 | Right element present |
| rightReady | output | 1 | Right element consumed this cycle |
| rightKey | input | 32 | Right key |
| rightPay | input | 32 | Right payload |
| rightLast | input | 1 | Right element is the final one |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream accepts the beat |
| outKey | output | 32 | Key of the beat |
| outLeftPay | output | 32 | Left payload |
| outRightPay | output | 32 | Right payload, 0 on a miss |
| outHit | output | 1 | Match mask bit |
| joinDone | output | 1 | Join finished |
| overflowErr | output | 1 | Sticky run-overflow flag |

## Verification
Two events can land in the same cycle: the overflow of the replay buffer, and the closing of a group because the right stream has ended. A right run of eighteen equal keys whose final element carries the last flag provokes exactly this. The bench then checks that overflowErr is set, that each left partner gets only sixteen pairs, and that the join still finishes. A second collision, between replay stepping and output backpressure, is exercised by random outReady. Each beat is compared in order against a model of the merge computed in the bench.

// File: rtl/mj_pkg.sv
package mj_pkg;

  typedef enum logic [1:0] {
    ST_MERGE,
    ST_COLLECT,
    ST_REPLAY,
    ST_DONE
  } mjState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic consumeL;
    logic consumeR;
    logic startGrp;
    logic pushR;
    logic emitMiss;
    logic emitPair;
    logic stepIdx;
    logic wrapIdx;
    logic endGrp;
  } mjStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lLtR;
    logic lEqR;
    logic lEqG;
    logic rEqG;
    logic idxLast;
    logic canEmit;
  } mjFlag_t;

endpackage

// File: rtl/mj_ctrl.sv
module mj_ctrl
  import mj_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      leftValid,
  input  logic      leftLast,
  input  logic      rightValid,
  input  logic      rightLast,
  input  mjFlag_t   flags,
  output mjStrobe_t strb,
  output logic      joinDone
);

  mjState_e stQ, stNxt;
  logic     rightEndedQ;

  always_comb begin
    strb  = '0;
    stNxt = stQ;
    unique case (stQ)
      ST_MERGE: begin
        if (leftValid && rightValid && flags.canEmit) begin
          if (flags.lLtR) begin
            strb.consumeL = 1'b1;
            strb.emitMiss = 1'b1;
            if (leftLast) stNxt = ST_DONE;
          end else if (!flags.lEqR) begin
            strb.consumeR = 1'b1;
            if (rightLast) stNxt = ST_DONE;
          end else begin
            strb.consumeR = 1'b1;
            strb.startGrp = 1'b1;
            stNxt = rightLast ? ST_REPLAY : ST_COLLECT;
          end
        end
      end
      ST_COLLECT: begin
        if (rightValid) begin
          if (flags.rEqG) begin
            strb.consumeR = 1'b1;
            strb.pushR    = 1'b1;
            if (rightLast) stNxt = ST_REPLAY;
          end else begin
            stNxt = ST_REPLAY;
          end
        end
      end
      ST_REPLAY: begin
        if (leftValid && flags.canEmit) begin
          if (flags.lEqG) begin
            strb.emitPair = 1'b1;
            if (flags.idxLast) begin
              strb.consumeL = 1'b1;
              strb.wrapIdx  = 1'b1;
              if (leftLast) stNxt = ST_DONE;
            end else begin
              strb.stepIdx = 1'b1;
            end
          end else begin
            strb.endGrp = 1'b1;
            stNxt = rightEndedQ ? ST_DONE : ST_MERGE;
          end
        end
      end
      default: stNxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ         <= ST_MERGE;
      rightEndedQ <= 1'b0;
    end else begin
      stQ <= stNxt;
      if (strb.consumeR && rightLast) rightEndedQ <= 1'b1;
    end
  end

  assign joinDone = (stQ == ST_DONE);

endmodule

// File: rtl/mj_datapath.sv
module mj_datapath
  import mj_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int PAY_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEY_W-1:0] leftKey,
  input  logic [PAY_W-1:0] leftPay,
  input  logic [KEY_W-1:0] rightKey,
  input  logic [PAY_W-1:0] rightPay,
  input  mjStrobe_t        strb,
  output mjFlag_t          flags,
  input  logic             outReady,
  output logic             outValid,
  output logic [KEY_W-1:0] outKey,
  output logic [PAY_W-1:0] outLeftPay,
  output logic [PAY_W-1:0] outRightPay,
  output logic             outHit,
  output logic             overflowErr
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PAY_W-1:0] runBuf [DEPTH];
  logic [KEY_W-1:0] grpKey;
  logic [CNT_W-1:0] runCnt;
  logic [IDX_W-1:0] rdIdx;

  assign flags.lLtR    = leftKey < rightKey;
  assign flags.lEqR    = leftKey == rightKey;
  assign flags.lEqG    = leftKey == grpKey;
  assign flags.rEqG    = rightKey == grpKey;
  assign flags.idxLast = (CNT_W'(rdIdx) + CNT_W'(1)) == runCnt;
  assign flags.canEmit = !outValid || outReady;

  // replay storage, no reset needed
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if ((strb.startGrp && e == 0) ||
          (strb.pushR && runCnt == CNT_W'(e)))
        runBuf[e] <= rightPay;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpKey      <= '0;
      runCnt      <= '0;
      rdIdx       <= '0;
      overflowErr <= 1'b0;
    end else begin
      if (strb.startGrp) begin
        grpKey <= rightKey;
        runCnt <= CNT_W'(1);
        rdIdx  <= '0;
      end else if (strb.pushR) begin
        if (runCnt < FULL_CNT) runCnt <= runCnt + CNT_W'(1);
        else                   overflowErr <= 1'b1;
      end
      if (strb.stepIdx) rdIdx <= rdIdx + IDX_W'(1);
      if (strb.wrapIdx) rdIdx <= '0;
      if (strb.endGrp) begin
        runCnt <= '0;
        rdIdx  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outKey      <= '0;
      outLeftPay  <= '0;
      outRightPay <= '0;
      outHit      <= 1'b0;
    end else if (strb.emitMiss) begin
      outValid    <= 1'b1;
      outKey      <= leftKey;
      outLeftPay  <= leftPay;
      outRightPay <= '0;
      outHit      <= 1'b0;
    end else if (strb.emitPair) begin
      outValid    <= 1'b1;
      outKey      <= leftKey;
      outLeftPay  <= leftPay;
      outRightPay <= runBuf[rdIdx];
      outHit      <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/merge_join_unit.sv
module merge_join_unit
  import mj_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int PAY_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             leftValid,
  output logic             leftReady,
  input  logic [KEY_W-1:0] leftKey,
  input  logic [PAY_W-1:0] leftPay,
  input  logic             leftLast,
  input  logic             rightValid,
  output logic             rightReady,
  input  logic [KEY_W-1:0] rightKey,
  input  logic [PAY_W-1:0] rightPay,
  input  logic             rightLast,
  output logic             outValid,
  input  logic             outReady,
  output logic [KEY_W-1:0] outKey,
  output logic [PAY_W-1:0] outLeftPay,
  output logic [PAY_W-1:0] outRightPay,
  output logic             outHit,
  output logic             joinDone,
  output logic             overflowErr
);

  mjStrobe_t strb;
  mjFlag_t   flags;

  mj_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .leftValid  (leftValid),
    .leftLast   (leftLast),
    .rightValid (rightValid),
    .rightLast  (rightLast),
    .flags      (flags),
    .strb       (strb),
    .joinDone   (joinDone)
  );

  mj_datapath #(
    .KEY_W (KEY_W),
    .PAY_W (PAY_W),
    .DEPTH (DEPTH)
  ) dpath (
    .clk         (clk),
    .rstN        (rstN),
    .leftKey     (leftKey),
    .leftPay     (leftPay),
    .rightKey    (rightKey),
    .rightPay    (rightPay),
    .strb        (strb),
    .flags       (flags),
    .outReady    (outReady),
    .outValid    (outValid),
    .outKey      (outKey),
    .outLeftPay  (outLeftPay),
    .outRightPay (outRightPay),
    .outHit      (outHit),
    .overflowErr (overflowErr)
  );

  assign leftReady  = strb.consumeL;
  assign rightReady = strb.consumeR;

endmodule

// File: rtl/mj_join_chk.sv
module mj_join_chk #(
  parameter int KEY_W = 32,
  parameter int PAY_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             leftValid,
  input logic             leftReady,
  input logic             rightValid,
  input logic             rightReady,
  input logic             outValid,
  input logic             outReady,
  input logic [KEY_W-1:0] outKey,
  input logic [PAY_W-1:0] outLeftPay,
  input logic [PAY_W-1:0] outRightPay,
  input logic             outHit,
  input logic             joinDone,
  input logic             overflowErr
);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outKey) && $stable(outLeftPay)
                              && $stable(outRightPay) && $stable(outHit));

  // R3
  one_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && leftReady && rightValid && rightReady));

  // R2
  miss_pay_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outHit |-> outRightPay == '0);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    joinDone |-> !leftReady && !rightReady);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    joinDone |=> joinDone);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

endmodule

bind merge_join_unit mj_join_chk #(.KEY_W(KEY_W), .PAY_W(PAY_W)) joinChk (
  .clk         (clk),
  .rstN        (rstN),
  .leftValid   (leftValid),
  .leftReady   (leftReady),
  .rightValid  (rightValid),
  .rightReady  (rightReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .outKey      (outKey),
  .outLeftPay  (outLeftPay),
  .outRightPay (outRightPay),
  .outHit      (outHit),
  .joinDone    (joinDone),
  .overflowErr (overflowErr)
);

// File: tb/merge_join_unit_test.sv
module merge_join_unit_test;

  localparam int DEPTH  = 16;
  localparam int MAXN   = 32;
  localparam int MAXOUT = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        leftValid = 1'b0, leftLast = 1'b0, leftReady;
  logic [31:0] leftKey = '0, leftPay = '0;
  logic        rightValid = 1'b0, rightLast = 1'b0, rightReady;
  logic [31:0] rightKey = '0, rightPay = '0;
  logic        outValid, outReady = 1'b0, outHit, joinDone, overflowErr;
  logic [31:0] outKey, outLeftPay, outRightPay;

  always #2 clk = ~clk;

  merge_join_unit #(.KEY_W(32), .PAY_W(32), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN),
    .leftValid(leftValid), .leftReady(leftReady), .leftKey(leftKey),
    .leftPay(leftPay), .leftLast(leftLast),
    .rightValid(rightValid), .rightReady(rightReady), .rightKey(rightKey),
    .rightPay(rightPay), .rightLast(rightLast),
    .outValid(outValid), .outReady(outReady), .outKey(outKey),
    .outLeftPay(outLeftPay), .outRightPay(outRightPay), .outHit(outHit),
    .joinDone(joinDone), .overflowErr(overflowErr)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] lk [MAXN];
  logic [31:0] lp [MAXN];
  logic [31:0] rk [MAXN];
  logic [31:0] rp [MAXN];
  int nl, nr;

  logic [31:0] eKey [MAXOUT];
  logic [31:0] eLp  [MAXOUT];
  logic [31:0] eRp  [MAXOUT];
  logic        eHit [MAXOUT];
  int  nExp;
  logic expOvf;

  function automatic void check(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endfunction

  function automatic void addExp(input logic [31:0] k, input logic [31:0] a,
                                 input logic [31:0] b, input logic h);
    if (nExp < MAXOUT) begin
      eKey[nExp] = k; eLp[nExp] = a; eRp[nExp] = b; eHit[nExp] = h;
    end
    nExp++;
  endfunction

  // merge model from the requirements
  function automatic void buildExp();
    int i = 0, j = 0;
    bit fin = 0;
    nExp = 0;
    expOvf = 0;
    while (!fin) begin
      if (lk[i] < rk[j]) begin
        addExp(lk[i], lp[i], 32'd0, 1'b0);
        i++;
        if (i == nl) fin = 1;
      end else if (lk[i] > rk[j]) begin
        j++;
        if (j == nr) fin = 1;
      end else begin
        logic [31:0] g = rk[j];
        logic [31:0] run [DEPTH];
        int cnt = 0;
        bit rEnd;
        while (j < nr && rk[j] == g) begin
          if (cnt < DEPTH) begin run[cnt] = rp[j]; cnt++; end
          else expOvf = 1;
          j++;
        end
        rEnd = (j == nr);
        while (!fin && lk[i] == g) begin
          for (int q = 0; q < cnt; q++) addExp(g, lp[i], run[q], 1'b1);
          i++;
          if (i == nl) fin = 1;
        end
        if (rEnd) fin = 1;
      end
    end
  endfunction

  task automatic runCase(input string name, input int readyMode, input int gapMode);
    int li = 0, ri = 0, got = 0, cyc = 0;
    buildExp();
    rstN = 1'b0;
    leftValid = 1'b0; rightValid = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    check(!outValid && !joinDone && !overflowErr, "R1 reset state",
          {29'd0, outValid, joinDone, overflowErr}, 32'd0);
    while (!(joinDone && !outValid) && cyc < 3000) begin
      @(negedge clk);
      leftValid = (li < nl) && (gapMode == 0 || ($urandom % 4) != 0);
      if (li < nl) begin
        leftKey = lk[li]; leftPay = lp[li]; leftLast = (li == nl - 1);
      end
      rightValid = (ri < nr) && (gapMode == 0 || ($urandom % 4) != 0);
      if (ri < nr) begin
        rightKey = rk[ri]; rightPay = rp[ri]; rightLast = (ri == nr - 1);
      end
      outReady = (readyMode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (joinDone) begin
        // R7
        check(!leftReady && !rightReady, "R7 no input taken after done",
              {30'd0, leftReady, rightReady}, 32'd0);
      end
      if (leftValid && leftReady) li++;
      if (rightValid && rightReady) ri++;
      if (outValid && outReady) begin
        if (got < nExp && got < MAXOUT) begin
          if (eHit[got]) begin
            // R4 / R5 ordering of pairs
            check(outHit == 1'b1 && outKey == eKey[got], "R4 pair key/hit", outKey, eKey[got]);
            check(outLeftPay == eLp[got], "R5 pair left payload order", outLeftPay, eLp[got]);
            check(outRightPay == eRp[got], "R5 pair right payload order", outRightPay, eRp[got]);
          end else begin
            // R2
            check(outHit == 1'b0 && outKey == eKey[got], "R2 miss key/hit", outKey, eKey[got]);
            check(outLeftPay == eLp[got] && outRightPay == 32'd0, "R2 miss payloads",
                  outRightPay, 32'd0);
          end
        end else begin
          check(1'b0, "R3 unexpected extra beat", outKey, 32'd0);
        end
        got++;
      end
      cyc++;
    end
    if (cyc >= 3000) check(1'b0, {"watchdog ", name}, cyc, 32'd0);
    leftValid = 1'b0; rightValid = 1'b0;
    // R3 R5: right-only steps emit nothing, pair count exact
    check(got == nExp, {"R3 R5 beat count ", name}, got, nExp);
    // R7
    check(joinDone == 1'b1, {"R7 done ", name}, {31'd0, joinDone}, 32'd1);
    // R8
    check(overflowErr == expOvf, {"R8 overflow flag ", name}, {31'd0, overflowErr}, {31'd0, expOvf});
  endtask

  task automatic randomArrays();
    logic [31:0] cur;
    nl = 1 + ($urandom % 24);
    nr = 1 + ($urandom % 24);
    cur = $urandom % 3;
    for (int x = 0; x < nl; x++) begin
      if (($urandom % 3) == 0) cur = cur + 1 + ($urandom % 2);
      lk[x] = cur; lp[x] = $urandom;
    end
    cur = $urandom % 3;
    for (int x = 0; x < nr; x++) begin
      if (($urandom % 3) == 0) cur = cur + 1 + ($urandom % 2);
      rk[x] = cur; rp[x] = $urandom;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));

    // basic interleave: R2 R3 R4
    nl = 3; lk[0] = 1; lk[1] = 3; lk[2] = 5;
    nr = 4; rk[0] = 2; rk[1] = 3; rk[2] = 4; rk[3] = 6;
    for (int x = 0; x < MAXN; x++) begin lp[x] = 32'h100 + x; rp[x] = 32'h200 + x; end
    runCase("interleave", 0, 0);

    // cross product 3x2: R5
    nl = 4; lk[0] = 5; lk[1] = 5; lk[2] = 5; lk[3] = 7;
    nr = 3; rk[0] = 5; rk[1] = 5; rk[2] = 9;
    runCase("cross", 1, 0);

    // right run of 18 ending on last: overflow and group close together, R8 R9
    nl = 2; lk[0] = 8; lk[1] = 8;
    nr = 18;
    for (int x = 0; x < 18; x++) rk[x] = 8;
    runCase("overflow R8 R9", 1, 0);

    // right ends inside a run, left continues: R9
    nl = 5; lk[0] = 4; lk[1] = 4; lk[2] = 4; lk[3] = 9; lk[4] = 10;
    nr = 3; rk[0] = 1; rk[1] = 4; rk[2] = 4;
    runCase("right ends R9", 0, 1);

    // left ends first: R7
    nl = 2; lk[0] = 1; lk[1] = 2;
    nr = 2; rk[0] = 5; rk[1] = 6;
    runCase("left ends R7", 0, 0);

    for (int t = 0; t < 40; t++) begin
      randomArrays();
      runCase("random", t % 2, (t / 2) % 2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule